// File: doc/BRIEF.md
# UART Receiver with Error Flags

This block receives asynchronous serial frames on one input line. A 16x oversampling tick comes from outside and paces all sampling. The line can be inverted, and it can be taken either straight from the pin or through a two-stage synchronizer.

After a falling edge, the block checks the start bit at its middle. It then samples every data bit, the optional parity bit and the stop bit at mid-bit and rebuilds the data word. The word length is set by a configuration input, and the data may arrive least or most significant bit first. Each finished word goes into a two-entry receive buffer with three status bits placed above the data. A reader drains the buffer through a simple pop port.

Sticky flags report parity errors, framing errors, break conditions and buffer overrun. A one-cycle clear pulse removes them. A busy output shows that a frame is in progress. Baud generation sits outside the block.

Top module: `uart_rx_core`

## Requirements
- R1: The conditioned line equals `rx_pin` XOR `cfg_rx_invert`. When `cfg_use_sync` is 1 the line passes through two flip-flops. When it is 0 the line is taken directly. Frames are received correctly in all four combinations.
- R2: The start bit is checked at oversample tick 8 after the first low tick. If the line is high again at that point, the event is a glitch: no word is stored and busy returns to 0.
- R3: The word length is `cfg_word_len`, clamped to 6..13. When `cfg_lsb_first` is 1 the first data bit is bit 0; when it is 0 the first data bit is bit len-1. Data is right-aligned in `rd_data[12:0]`, and every data bit at or above len reads 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_even`=1 expects an even count of ones over data plus parity; 0 expects an odd count. A mismatch sets `rd_data[13]` of the stored word.
- R5: If the first stop bit is sampled as 0, `rd_data[14]` of the stored word is set. The word is stored once the line returns high.
- R6: If the line stays low for more than (1+len+parity+stop bits)×16 ticks, `rd_data[15]` is set, together with bit 14. A low period shorter than this sets bit 14 only.
- R7: The buffer holds 2 words in arrival order. `rx_empty` and `rx_full` reflect its level, `rd_data` shows the oldest word, and `rd_en` pops it. A pop while the buffer is empty changes nothing.
- R8: `err_break`, `err_frame` and `err_parity` are set by a stored word carrying the matching status bit. They stay set until a `clr_err` pulse, which clears all three together.
- R9: A word that completes while the buffer is full is dropped and sets `rx_overrun`. The buffer contents are unchanged. `clr_ovr` clears the flag.
- R10: `rx_busy` is 1 from start detection until the frame is stored or discarded.
- R11: After reset, the buffer is empty, all flags are 0 and `rx_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Serial receive line |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| cfg_rx_invert | input | 1 | Invert the receive line |
| cfg_use_sync | input | 1 | 1: use synchronized line, 0: raw line |
| cfg_word_len | input | 4 | Data bits per frame (6..13) |
| cfg_lsb_first | input | 1 | 1: bit 0 arrives first |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_two_stop | input | 1 | Two stop bits in the frame time |
| rd_en | input | 1 | Pop the oldest buffered word |
| rd_data | output | 16 | Oldest word: break, framing, parity, data |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer full |
| clr_err | input | 1 | Clear the three error flags |
| clr_ovr | input | 1 | Clear the overrun flag |
| err_break | output | 1 | Sticky break flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_busy | output | 1 | Frame reception in progress |

## Verification
The properties assume a few things about the inputs. `os_tick` is a single-cycle pulse. The configuration inputs change only while the receiver is idle. A pop never coincides with a word arriving into a full buffer.

The stimulus respects these assumptions. It changes the configuration only between frames, and it flips the inversion together with the line level so the conditioned line stays high. Buffer reads happen well after a frame has been stored. Frames with a bad stop bit always carry at least one 1 in their data, so only the directed break cases can reach the break threshold.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;
  localparam int OS_RATE  = 16;
  localparam int DATA_MIN = 6;
  localparam int DATA_MAX = 13;
  localparam int LEN_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uartrx_line_cond.sv
module uartrx_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic invert,
  input  logic use_sync,
  output logic rx_cond
);
  logic raw;
  logic sync_out;

  assign raw = rx_pin ^ invert;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_STAGES-2:0], raw};
      end
      assign sync_out = chain[SYNC_STAGES-1];
    end else begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= 1'b1;
        else     stage <= raw;
      end
      assign sync_out = stage;
    end
  endgenerate

  assign rx_cond = use_sync ? sync_out : raw;
endmodule

// File: rtl/uartrx_frame.sv
module uartrx_frame
  import uartrx_pkg::*;
#(
  parameter int OS     = 16,
  parameter int DMIN   = 6,
  parameter int DMAX   = 13,
  parameter int LW     = 4,
  parameter int WORD_W = DMAX + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_bit,
  input  logic [LW-1:0]     cfg_word_len,
  input  logic              cfg_lsb_first,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data,
  output logic              busy
);
  localparam int CNT_W = $clog2(OS);
  localparam int IDX_W = $clog2(DMAX + 1);
  localparam int LOW_W = $clog2((DMAX + 4) * OS + 2);
  localparam logic [CNT_W-1:0] T_MID  = CNT_W'(OS - 1);
  localparam logic [CNT_W-1:0] T_HALF = CNT_W'(OS / 2 - 1);
  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};

  rx_state_e         state;
  logic [CNT_W-1:0]  tcnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  eff_len;
  logic [IDX_W-1:0]  wr_idx;
  logic [DMAX-1:0]   shreg;
  logic              dpar;
  logic              perr;
  logic              brk_seen;
  logic [LOW_W-1:0]  low_cnt;
  logic [LOW_W-1:0]  thresh;

  always_comb begin
    if (cfg_word_len < LW'(DMIN))      eff_len = IDX_W'(DMIN);
    else if (cfg_word_len > LW'(DMAX)) eff_len = IDX_W'(DMAX);
    else                               eff_len = IDX_W'(cfg_word_len);
  end

  assign thresh = LOW_W'((32'(eff_len) + 32'd2 + 32'(cfg_par_en) + 32'(cfg_two_stop)) * OS);
  assign wr_idx = cfg_lsb_first ? bit_idx : (eff_len - IDX_W'(1) - bit_idx);
  assign busy   = (state != ST_IDLE);

  // low-level run length, counted in ticks, used for break detection
  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (os_tick) begin
      if (rx_bit)                low_cnt <= '0;
      else if (low_cnt != LOW_MAX) low_cnt <= low_cnt + LOW_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      dpar      <= 1'b0;
      perr      <= 1'b0;
      brk_seen  <= 1'b0;
      word_push <= 1'b0;
      word_data <= '0;
    end else begin
      word_push <= 1'b0;
      if (os_tick && !rx_bit && (low_cnt >= thresh)) brk_seen <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (os_tick && !rx_bit) begin
            state    <= ST_START;
            tcnt     <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            dpar     <= 1'b0;
            perr     <= 1'b0;
            brk_seen <= 1'b0;
          end
        end
        ST_START: begin
          if (os_tick) begin
            if (tcnt == T_HALF) begin
              tcnt  <= '0;
              state <= rx_bit ? ST_IDLE : ST_DATA;
            end else tcnt <= tcnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (os_tick) begin
            if (tcnt == T_MID) begin
              tcnt          <= '0;
              shreg[wr_idx] <= rx_bit;
              dpar          <= dpar ^ rx_bit;
              bit_idx       <= bit_idx + IDX_W'(1);
              if (bit_idx == eff_len - IDX_W'(1))
                state <= cfg_par_en ? ST_PARITY : ST_STOP;
            end else tcnt <= tcnt + CNT_W'(1);
          end
        end
        ST_PARITY: begin
          if (os_tick) begin
            if (tcnt == T_MID) begin
              tcnt  <= '0;
              perr  <= dpar ^ rx_bit ^ !cfg_par_even;
              state <= ST_STOP;
            end else tcnt <= tcnt + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (os_tick) begin
            if (tcnt == T_MID) begin
              tcnt <= '0;
              if (rx_bit) begin
                word_push <= 1'b1;
                word_data <= {1'b0, 1'b0, perr, shreg};
                state     <= ST_IDLE;
              end else state <= ST_HOLD;
            end else tcnt <= tcnt + CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (os_tick && rx_bit) begin
            word_push <= 1'b1;
            word_data <= {brk_seen, 1'b1, perr, shreg};
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uartrx_buffer.sv
module uartrx_buffer #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             overrun_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level;
  logic             wr_ok, rd_ok;

  assign empty       = (level == '0);
  assign full        = (level == CNT_W'(DEPTH));
  assign wr_ok       = push && !full;
  assign rd_ok       = pop && !empty;
  assign overrun_evt = push && full;
  assign dout        = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uartrx_pkg::*;
#(
  parameter int OS_RATE_P  = OS_RATE,
  parameter int DATA_MIN_P = DATA_MIN,
  parameter int DATA_MAX_P = DATA_MAX,
  parameter int LEN_W_P    = LEN_W,
  parameter int BUF_DEPTH  = 2,
  parameter int SYNC_STAGE = 2,
  parameter int WORD_W     = DATA_MAX_P + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_pin,
  input  logic               os_tick,
  input  logic               cfg_rx_invert,
  input  logic               cfg_use_sync,
  input  logic [LEN_W_P-1:0] cfg_word_len,
  input  logic               cfg_lsb_first,
  input  logic               cfg_par_en,
  input  logic               cfg_par_even,
  input  logic               cfg_two_stop,
  input  logic               rd_en,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rx_empty,
  output logic               rx_full,
  input  logic               clr_err,
  input  logic               clr_ovr,
  output logic               err_break,
  output logic               err_frame,
  output logic               err_parity,
  output logic               rx_overrun,
  output logic               rx_busy
);
  localparam int B_BRK = WORD_W - 1;
  localparam int B_FRM = WORD_W - 2;
  localparam int B_PAR = WORD_W - 3;

  logic              rx_cond;
  logic              word_push;
  logic [WORD_W-1:0] word_data;
  logic              ovr_evt;

  uartrx_line_cond #(.SYNC_STAGES(SYNC_STAGE)) u_cond (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .invert(cfg_rx_invert),
    .use_sync(cfg_use_sync), .rx_cond(rx_cond)
  );

  uartrx_frame #(
    .OS(OS_RATE_P), .DMIN(DATA_MIN_P), .DMAX(DATA_MAX_P), .LW(LEN_W_P), .WORD_W(WORD_W)
  ) u_frame (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_bit(rx_cond),
    .cfg_word_len(cfg_word_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .word_push(word_push), .word_data(word_data), .busy(rx_busy)
  );

  uartrx_buffer #(.WIDTH(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(word_push), .din(word_data), .pop(rd_en),
    .dout(rd_data), .empty(rx_empty), .full(rx_full), .overrun_evt(ovr_evt)
  );

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      err_break  <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      err_break  <= (err_break  && !clr_err) || (word_push && word_data[B_BRK]);
      err_frame  <= (err_frame  && !clr_err) || (word_push && word_data[B_FRM]);
      err_parity <= (err_parity && !clr_err) || (word_push && word_data[B_PAR]);
      rx_overrun <= (rx_overrun && !clr_ovr) || ovr_evt;
    end
  end
endmodule

// File: rtl/uartrx_checker.sv
module uartrx_checker (
  input logic clk,
  input logic rst,
  input logic os_tick,
  input logic rx_cond,
  input logic word_push,
  input logic rd_en,
  input logic rx_empty,
  input logic rx_full,
  input logic clr_err,
  input logic clr_ovr,
  input logic err_break,
  input logic err_frame,
  input logic err_parity,
  input logic rx_overrun,
  input logic rx_busy
);
  // R7: level flags never both set
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full));

  // R7: popping an empty buffer leaves it empty
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
    rx_empty && !word_push |=> rx_empty);

  // R9: a word arriving at a full buffer raises overrun
  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
    word_push && rx_full |=> rx_overrun);

  // R9: clear removes overrun when no new overrun arrives
  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_ovr && !word_push |=> !rx_overrun);

  // R8: one clear pulse drops all three error flags
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_err && !word_push |=> !err_break && !err_frame && !err_parity);

  // R10: busy only starts on a tick that sees the line low
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_busy) |-> $past(os_tick) && !$past(rx_cond));

  // R6: break never appears without a framing error
  assert_break_implies_frame_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_break) |-> err_frame);
endmodule

bind uart_rx_core uartrx_checker u_chk (
  .clk(clk), .rst(rst), .os_tick(os_tick), .rx_cond(rx_cond),
  .word_push(word_push), .rd_en(rd_en), .rx_empty(rx_empty), .rx_full(rx_full),
  .clr_err(clr_err), .clr_ovr(clr_ovr), .err_break(err_break), .err_frame(err_frame),
  .err_parity(err_parity), .rx_overrun(rx_overrun), .rx_busy(rx_busy)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int OSR        = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_pin = 1'b1;
  logic        os_tick = 1'b0;
  logic        cfg_rx_invert = 1'b0;
  logic        cfg_use_sync = 1'b1;
  logic [3:0]  cfg_word_len = 4'd8;
  logic        cfg_lsb_first = 1'b1;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_even = 1'b0;
  logic        cfg_two_stop = 1'b0;
  logic        rd_en = 1'b0;
  logic        clr_err = 1'b0;
  logic        clr_ovr = 1'b0;
  logic [15:0] rd_data;
  logic        rx_empty, rx_full, err_break, err_frame, err_parity, rx_overrun, rx_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  uart_rx_core dut (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .os_tick(os_tick),
    .cfg_rx_invert(cfg_rx_invert), .cfg_use_sync(cfg_use_sync),
    .cfg_word_len(cfg_word_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .rd_en(rd_en), .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .clr_err(clr_err), .clr_ovr(clr_ovr), .err_break(err_break), .err_frame(err_frame),
    .err_parity(err_parity), .rx_overrun(rx_overrun), .rx_busy(rx_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : tick_gen
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
      os_tick = (div == 0);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic set_line(input logic b);
    rx_pin = b ^ cfg_rx_invert;
  endtask

  function automatic logic [12:0] len_mask(input int len);
    return 13'((32'd1 << len) - 1);
  endfunction

  function automatic logic [15:0] exp_word(input logic brk, input logic ferr,
                                           input logic perr, input logic [12:0] d);
    return {brk, ferr, perr, d};
  endfunction

  // sends one frame using the current configuration
  task automatic send_frame(input logic [12:0] d, input bit bad_par, input bit bad_stop);
    int   len;
    logic pb;
    logic b;
    len = int'(cfg_word_len);
    set_line(1'b0);
    hold_ticks(OSR);
    for (int i = 0; i < len; i++) begin
      b = cfg_lsb_first ? d[i] : d[len-1-i];
      set_line(b);
      if (i == 1) begin
        hold_ticks(OSR/2);
        check("R10 busy mid-frame", 32'(rx_busy), 32'd1);
        hold_ticks(OSR/2);
      end else hold_ticks(OSR);
    end
    if (cfg_par_en) begin
      pb = ^(d & len_mask(len));
      if (!cfg_par_even) pb = ~pb;
      if (bad_par) pb = ~pb;
      set_line(pb);
      hold_ticks(OSR);
    end
    set_line(!bad_stop);
    hold_ticks(OSR);
    if (cfg_two_stop) begin
      set_line(1'b1);
      hold_ticks(OSR);
    end
    set_line(1'b1);
    hold_ticks(2 * OSR);
  endtask

  task automatic pop_word();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_clr_err();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [12:0] d;
    bit bp, bs;
    void'($urandom(32'h1d5a7));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 empty", 32'(rx_empty), 32'd1);
    check("R11 full", 32'(rx_full), 32'd0);
    check("R11 flags", {28'd0, err_break, err_frame, err_parity, rx_overrun}, 32'd0);
    check("R11 busy", 32'(rx_busy), 32'd0);
    hold_ticks(2 * OSR);

    // R2 glitch shorter than half a bit
    set_line(1'b0);
    hold_ticks(5);
    set_line(1'b1);
    hold_ticks(3 * OSR);
    check("R2 glitch no word", 32'(rx_empty), 32'd1);
    check("R2 glitch busy low", 32'(rx_busy), 32'd0);

    // R3 MSB first, 8 bits, no parity
    cfg_lsb_first = 1'b0;
    send_frame(13'h0A5, 1'b0, 1'b0);
    check("R3 msb-first word", 32'(rd_data), 32'(exp_word(0, 0, 0, 13'h0A5)));
    pop_word();
    check("R7 empty after pop", 32'(rx_empty), 32'd1);
    pop_word();
    check("R7 pop on empty", 32'(rx_empty), 32'd1);

    // R6 break: len 8, parity, two stop -> 12 bits = 192 ticks
    cfg_lsb_first = 1'b1; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_two_stop = 1'b1;
    set_line(1'b0);
    hold_ticks(14 * OSR);
    set_line(1'b1);
    hold_ticks(3 * OSR);
    check("R6 break word", 32'(rd_data), 32'h0000C000);
    check("R8 break flag", 32'(err_break), 32'd1);
    pop_word();
    pulse_clr_err();
    check("R8 clear all", {29'd0, err_break, err_frame, err_parity}, 32'd0);

    // R6 near miss: 11 bits low, below threshold
    set_line(1'b0);
    hold_ticks(11 * OSR);
    set_line(1'b1);
    hold_ticks(3 * OSR);
    check("R6 short low no break", 32'(rd_data), 32'h00004000);
    pop_word();
    pulse_clr_err();

    // R9 overrun with 3 words, 6-bit LSB first no parity
    cfg_word_len = 4'd6; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    send_frame(13'h15, 1'b0, 1'b0);
    send_frame(13'h2A, 1'b0, 1'b0);
    check("R7 full at two", 32'(rx_full), 32'd1);
    check("R9 no overrun yet", 32'(rx_overrun), 32'd0);
    send_frame(13'h3F, 1'b0, 1'b0);
    check("R9 overrun set", 32'(rx_overrun), 32'd1);
    check("R9 head kept", 32'(rd_data), 32'h15);
    pop_word();
    check("R7 order second", 32'(rd_data), 32'h2A);
    pop_word();
    check("R7 empty", 32'(rx_empty), 32'd1);
    @(negedge clk); clr_ovr = 1'b1;
    @(negedge clk); clr_ovr = 1'b0;
    check("R9 overrun cleared", 32'(rx_overrun), 32'd0);

    // random frames: R1 R3 R4 R5 R8
    for (int k = 0; k < 24; k++) begin
      cfg_rx_invert = 1'($urandom % 2);
      set_line(1'b1);
      cfg_use_sync  = 1'($urandom % 2);
      cfg_word_len  = 4'(6 + ($urandom % 8));
      cfg_lsb_first = 1'($urandom % 2);
      cfg_par_en    = 1'($urandom % 2);
      cfg_par_even  = 1'($urandom % 2);
      cfg_two_stop  = 1'($urandom % 2);
      hold_ticks(2 * OSR);
      d  = 13'($urandom) & len_mask(int'(cfg_word_len));
      bp = cfg_par_en && (($urandom % 4) == 0);
      bs = (($urandom % 5) == 0);
      if (bs) d[0] = 1'b1;
      send_frame(d, bp, bs);
      check("R7 word stored", 32'(rx_empty), 32'd0);
      check("R1 R3 R4 R5 word", 32'(rd_data), 32'(exp_word(1'b0, bs, bp, d)));
      check("R8 parity flag", 32'(err_parity), 32'(bp));
      check("R8 frame flag", 32'(err_frame), 32'(bs));
      pop_word();
      pulse_clr_err();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule